// File: doc/BRIEF.md
# Dual-Mode Bus Arbitration Unit

This block manages ownership of a shared external bus for one on-chip master. Three bus pins carry the handshake: request, grant and busy. Each of them is active low and bidirectional at the pad, so the block drives a value and an output enable for each one. A strap input picks one of two roles. The strap is captured while reset is held and is not read again afterwards.

In the internal-arbiter role, the block grants the bus either to one external master or to the on-chip master. The on-chip master stands for a set of internal transfer sources, and each source carries a 3-bit priority. The external master's priority is a 3-bit input. The external master wins only when its priority is strictly above the highest pending internal priority, so a tie goes to the internal side. When nobody is requesting, the grant stays with the last holder. This is bus parking.

In the external-arbiter role, the block only raises a request and watches the grant pin. If the grant is already parked on this master, it raises no request. In both roles the on-chip master starts a tenure only when it holds the grant and sees busy negated. It then holds busy low until its transfer finishes. Next it drives busy high for one cycle and then releases the pin.

Top module: `bus_arb_unit`

## Requirements
- R1: While reset is high, all three output enables are low, gnt_n_o is high and own_o is low.
- R2: Strap value 0 selects the internal-arbiter role and 1 selects the external-arbiter role. From the first cycle after reset, the internal role drives grant (gnt_oe_o=1) and leaves request undriven (req_oe_o=0). The external role does the opposite.
- R3: Internal role: gnt_n_o goes low one cycle after an edge where req_n_i is low and ext_prio_i is strictly greater than the highest priority among the asserted int_req_i bits, or where no int_req_i bit is asserted.
- R4: Internal role: gnt_n_o is high one cycle after an edge where some int_req_i bit is asserted and ext_prio_i is less than or equal to the highest pending internal priority. Ties go to the internal side.
- R5: Internal role: after an edge with no external and no internal request, gnt_n_o keeps its previous value (parking).
- R6: External role: req_n_o goes low one cycle after an edge where an internal request is pending, gnt_n_i is high and the block does not own the bus. When gnt_n_i is low (parked on this master), req_n_o stays high.
- R7: own_o rises, with busy_oe_o=1 and busy_n_o=0, one cycle after an edge where an internal request is pending, the grant is held and busy_n_i is high. own_o stays low while busy_n_i is low.
- R8: Once own_o is high, own_o stays high and busy stays driven low until xfer_done_i is seen, even if the grant is withdrawn.
- R9: After the edge where xfer_done_i ends a tenure, own_o is low and busy is driven high (busy_oe_o=1, busy_n_o=1) for one cycle. The output enable is low one cycle later.
- R10: Changing the strap after reset has no effect on the role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap_i | input | 1 | Role strap: 0 internal arbiter, 1 external arbiter |
| int_req_i | input | N_SRC | Pending internal transfer sources |
| int_prio_i | input | N_SRC*PRIO_W | Priority of each internal source |
| ext_prio_i | input | PRIO_W | Programmed priority of the external master |
| xfer_done_i | input | 1 | The current transfer of the on-chip master ends |
| req_n_i | input | 1 | Request pad input (active low) |
| req_n_o | output | 1 | Request pad output value |
| req_oe_o | output | 1 | Request pad output enable |
| gnt_n_i | input | 1 | Grant pad input (active low) |
| gnt_n_o | output | 1 | Grant pad output value |
| gnt_oe_o | output | 1 | Grant pad output enable |
| busy_n_i | input | 1 | Busy pad input (active low) |
| busy_n_o | output | 1 | Busy pad output value |
| busy_oe_o | output | 1 | Busy pad output enable |
| own_o | output | 1 | Bus ownership indication to the internal bus interface |

## Verification
The bench looks for these corner cases and the failure each one would reveal:
- Equal priorities, which must favour the internal side. A design that compares with >= would hand the bus to the external master on a tie.
- Idle cycles, which must leave the grant parked. A design without parking would drop the grant to the external master.
- A busy line held low by another master, which must block takeover. A design that skips this check would drive busy on top of a live tenure.
- A grant withdrawn in mid-transfer. This must not end the tenure early. After the tenure ends, the pin must be driven high for exactly one cycle before it floats.
- In the external role, a grant that is already parked on this master must suppress the request.
- A strap toggled after reset must leave the role unchanged.

// File: rtl/bau_pkg.sv
package bau_pkg;

    localparam int PRIO_W_DEF = 3;
    localparam int N_SRC_DEF  = 3;

    typedef enum logic {
        ROLE_ARBITER = 1'b0,
        ROLE_CLIENT  = 1'b1
    } arb_role_e;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_HOLD = 2'd1,
        BS_DRAIN = 2'd2
    } busy_state_e;

    typedef struct packed {
        logic drive;
        logic level_n;
    } pad_drive_t;

endpackage

// File: rtl/bau_prio_max.sv
module bau_prio_max #(
    parameter int N_SRC  = 3,
    parameter int PRIO_W = 3
) (
    input  logic [N_SRC-1:0]             req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                         any_o,
    output logic [PRIO_W-1:0]            top_o
);

    always_comb begin
        any_o = 1'b0;
        top_o = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (req_i[k]) begin
                any_o = 1'b1;
                if (prio_i[k] > top_o) begin
                    top_o = prio_i[k];
                end
            end
        end
    end

endmodule

// File: rtl/bau_grant_sel.sv
module bau_grant_sel #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_want_i,
    input  logic [PRIO_W-1:0] ext_prio_i,
    input  logic              int_any_i,
    input  logic [PRIO_W-1:0] int_top_i,
    output logic              ext_granted_o
);

    logic ext_wins;
    logic ext_granted_q;

    assign ext_wins = ext_want_i && (!int_any_i || (ext_prio_i > int_top_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_granted_q <= 1'b0;
        end else if (ext_wins) begin
            ext_granted_q <= 1'b1;
        end else if (int_any_i) begin
            ext_granted_q <= 1'b0;
        end
    end

    assign ext_granted_o = ext_granted_q;

    // R3: a fresh grant to the external master follows a request from it
    a_r3_grant_follows_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_granted_q) |-> $past(ext_want_i));

    // R4: ties and lower external priority leave the bus with the internal side
    a_r4_tie_internal: assert property (@(posedge clk) disable iff (rst)
        (int_any_i && (ext_prio_i <= int_top_i)) |=> !ext_granted_q);

    // R5: with nobody asking, the grant stays parked
    a_r5_parking: assert property (@(posedge clk) disable iff (rst)
        (!ext_want_i && !int_any_i) |=> $stable(ext_granted_q));

endmodule

// File: rtl/bau_req_gen.sv
module bau_req_gen (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic pend_i,
    input  logic gnt_n_i,
    input  logic idle_i,
    output logic req_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= active_i && pend_i && gnt_n_i && idle_i;
        end
    end

    assign req_o = req_q;

    // R6: no request is raised while the grant is parked on this master
    a_r6_no_req_when_parked: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(gnt_n_i));

endmodule

// File: rtl/bau_busy_fsm.sv
module bau_busy_fsm
    import bau_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       live_i,
    input  logic       pend_i,
    input  logic       grant_i,
    input  logic       busy_n_i,
    input  logic       done_i,
    output logic       own_o,
    output pad_drive_t busy_o
);

    busy_state_e state_q;
    busy_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:  if (live_i && pend_i && grant_i && busy_n_i) state_d = BS_HOLD;
            BS_HOLD:  if (done_i) state_d = BS_DRAIN;
            BS_DRAIN: state_d = BS_IDLE;
            default:  state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign own_o          = (state_q == BS_HOLD);
    assign busy_o.drive   = (state_q != BS_IDLE);
    assign busy_o.level_n = (state_q != BS_HOLD);

    // R7: ownership starts only with the grant held and busy negated
    a_r7_take_rules: assert property (@(posedge clk) disable iff (rst)
        $rose(own_o) |-> $past(grant_i && busy_n_i && pend_i));

    // R8: ownership persists until the transfer ends
    a_r8_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        (own_o && !done_i) |=> own_o);

    // R9: leaving ownership drives busy high for one cycle
    a_r9_drive_high: assert property (@(posedge clk) disable iff (rst)
        $fell(own_o) |-> (busy_o.drive && busy_o.level_n));

    // R9: then the pin floats
    a_r9_float: assert property (@(posedge clk) disable iff (rst)
        (busy_o.drive && busy_o.level_n) |=> !busy_o.drive);

endmodule

// File: rtl/bus_arb_unit.sv
module bus_arb_unit
    import bau_pkg::*;
#(
    parameter int N_SRC  = bau_pkg::N_SRC_DEF,
    parameter int PRIO_W = bau_pkg::PRIO_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_strap_i,
    input  logic [N_SRC-1:0]             int_req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] int_prio_i,
    input  logic [PRIO_W-1:0]            ext_prio_i,
    input  logic                         xfer_done_i,
    input  logic                         req_n_i,
    output logic                         req_n_o,
    output logic                         req_oe_o,
    input  logic                         gnt_n_i,
    output logic                         gnt_n_o,
    output logic                         gnt_oe_o,
    input  logic                         busy_n_i,
    output logic                         busy_n_o,
    output logic                         busy_oe_o,
    output logic                         own_o
);

    arb_role_e         role_q;
    logic              live_q;
    logic              int_any;
    logic [PRIO_W-1:0] int_top;
    logic              ext_granted;
    logic              self_grant;
    logic              req_raw;
    logic              is_arbiter;
    pad_drive_t        busy_pad;

    // Strap is captured only while reset is held (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            role_q <= arb_role_e'(mode_strap_i);
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    assign is_arbiter = (role_q == ROLE_ARBITER);

    bau_prio_max #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_prio (
        .req_i  (int_req_i),
        .prio_i (int_prio_i),
        .any_o  (int_any),
        .top_o  (int_top)
    );

    bau_grant_sel #(.PRIO_W(PRIO_W)) i_gsel (
        .clk           (clk),
        .rst           (rst),
        .ext_want_i    (is_arbiter && !req_n_i),
        .ext_prio_i    (ext_prio_i),
        .int_any_i     (int_any),
        .int_top_i     (int_top),
        .ext_granted_o (ext_granted)
    );

    assign self_grant = is_arbiter ? !ext_granted : !gnt_n_i;

    bau_busy_fsm i_busy (
        .clk      (clk),
        .rst      (rst),
        .live_i   (live_q),
        .pend_i   (int_any),
        .grant_i  (self_grant),
        .busy_n_i (busy_n_i),
        .done_i   (xfer_done_i),
        .own_o    (own_o),
        .busy_o   (busy_pad)
    );

    bau_req_gen i_req (
        .clk      (clk),
        .rst      (rst),
        .active_i (live_q && !is_arbiter),
        .pend_i   (int_any),
        .gnt_n_i  (gnt_n_i),
        .idle_i   (!busy_pad.drive),
        .req_o    (req_raw)
    );

    assign gnt_oe_o  = live_q && is_arbiter;
    assign gnt_n_o   = !(is_arbiter && ext_granted);
    assign req_oe_o  = live_q && !is_arbiter;
    assign req_n_o   = !req_raw;
    assign busy_oe_o = busy_pad.drive;
    assign busy_n_o  = busy_pad.level_n;

    // R2: exactly one of request and grant is driven once out of reset
    a_r2_one_direction: assert property (@(posedge clk) disable iff (rst)
        live_q |-> $onehot({req_oe_o, gnt_oe_o}));

    // R10: the role never changes outside reset
    a_r10_role_fixed: assert property (@(posedge clk) disable iff (rst)
        live_q |-> $stable(role_q));

endmodule

// File: tb/test_bus_arb_unit.sv
`timescale 1ns/1ps
module test_bus_arb_unit;

    localparam int N_SRC  = 3;
    localparam int PRIO_W = 3;
    localparam int NV     = 10;

    // {ext_req, ext_prio, int_req[2:0], p2, p1, p0, expect_ext_grant}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 3'd5, 3'b000, 3'd0, 3'd0, 3'd0, 1'b1},
        {1'b0, 3'd0, 3'b000, 3'd0, 3'd0, 3'd0, 1'b1},
        {1'b0, 3'd0, 3'b001, 3'd0, 3'd0, 3'd2, 1'b0},
        {1'b1, 3'd3, 3'b010, 3'd0, 3'd3, 3'd0, 1'b0},
        {1'b1, 3'd4, 3'b010, 3'd0, 3'd3, 3'd0, 1'b1},
        {1'b1, 3'd4, 3'b101, 3'd6, 3'd0, 3'd1, 1'b0},
        {1'b1, 3'd7, 3'b111, 3'd6, 3'd6, 3'd6, 1'b1},
        {1'b0, 3'd0, 3'b000, 3'd0, 3'd0, 3'd0, 1'b1},
        {1'b1, 3'd0, 3'b100, 3'd0, 3'd0, 3'd0, 1'b0},
        {1'b0, 3'd0, 3'b000, 3'd0, 3'd0, 3'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b0;
    logic [N_SRC-1:0] int_req = '0;
    logic [N_SRC-1:0][PRIO_W-1:0] int_prio = '0;
    logic [PRIO_W-1:0] ext_prio = '0;
    logic xfer_done = 1'b0;
    logic ext_req_n = 1'b1;
    logic ext_gnt_n = 1'b1;
    logic ext_busy_n = 1'b1;
    logic req_n_o, req_oe_o, gnt_n_o, gnt_oe_o, busy_n_o, busy_oe_o, own_o;
    logic busy_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    assign busy_line = (busy_oe_o ? busy_n_o : 1'b1) & ext_busy_n;

    bus_arb_unit #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_bus_arb_unit (
        .clk          (clk),
        .rst          (rst),
        .mode_strap_i (strap),
        .int_req_i    (int_req),
        .int_prio_i   (int_prio),
        .ext_prio_i   (ext_prio),
        .xfer_done_i  (xfer_done),
        .req_n_i      (ext_req_n),
        .req_n_o      (req_n_o),
        .req_oe_o     (req_oe_o),
        .gnt_n_i      (ext_gnt_n),
        .gnt_n_o      (gnt_n_o),
        .gnt_oe_o     (gnt_oe_o),
        .busy_n_i     (busy_line),
        .busy_n_o     (busy_n_o),
        .busy_oe_o    (busy_oe_o),
        .own_o        (own_o)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state, internal-arbiter strap
        @(negedge clk);
        step(3);
        chk("R1 oe during reset", {5'd0, req_oe_o, gnt_oe_o, busy_oe_o}, 8'd0);
        chk("R1 gnt_n during reset", {7'd0, gnt_n_o}, 8'd1);
        chk("R1 own during reset", {7'd0, own_o}, 8'd0);
        rst = 1'b0;
        step(1);
        chk("R2 arbiter role directions", {6'd0, req_oe_o, gnt_oe_o}, 8'b01);

        // R7 busy held by another master blocks takeover
        ext_busy_n = 1'b0;
        int_req = 3'b001;
        int_prio = '0;
        step(3);
        chk("R7 no take while busy low", {7'd0, own_o}, 8'd0);
        ext_busy_n = 1'b1;
        step(1);
        chk("R7 take after busy negated", {5'd0, own_o, busy_oe_o, busy_n_o}, 8'b110);

        // R3/R8 grant withdrawn while transfer runs
        ext_req_n = 1'b0;
        ext_prio = 3'd5;
        step(1);
        chk("R3 grant to higher external", {7'd0, gnt_n_o}, 8'd0);
        chk("R8 still own after withdraw", {6'd0, own_o, busy_n_o}, 8'b10);
        step(1);
        chk("R8 own held", {7'd0, own_o}, 8'd1);
        xfer_done = 1'b1;
        int_req = '0;
        step(1);
        chk("R9 drive high one cycle", {5'd0, own_o, busy_oe_o, busy_n_o}, 8'b011);
        xfer_done = 1'b0;
        step(1);
        chk("R9 release pin", {7'd0, busy_oe_o}, 8'd0);
        ext_req_n = 1'b1;

        // R3 R4 R5 priority table
        xfer_done = 1'b1;
        for (int v = 0; v < NV; v++) begin
            ext_req_n = !VEC[v][16];
            ext_prio  = VEC[v][15:13];
            int_req   = VEC[v][12:10];
            int_prio  = {VEC[v][9:7], VEC[v][6:4], VEC[v][3:1]};
            step(1);
            chk($sformatf("R3/R4/R5 vector %0d", v), {7'd0, gnt_n_o}, {7'd0, !VEC[v][0]});
        end
        xfer_done = 1'b0;
        int_req = '0;
        ext_req_n = 1'b1;

        // R10 strap ignored after reset
        strap = 1'b1;
        step(3);
        chk("R10 role unchanged", {6'd0, req_oe_o, gnt_oe_o}, 8'b01);

        // External-arbiter role
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        ext_gnt_n = 1'b1;
        step(1);
        chk("R2 client role directions", {6'd0, req_oe_o, gnt_oe_o}, 8'b10);
        chk("R6 no request when idle", {7'd0, req_n_o}, 8'd1);
        int_req = 3'b001;
        step(1);
        chk("R6 request raised", {7'd0, req_n_o}, 8'd0);
        chk("R7 no own without grant", {7'd0, own_o}, 8'd0);
        ext_gnt_n = 1'b0;
        step(1);
        chk("R7 own on external grant", {7'd0, own_o}, 8'd1);
        chk("R6 request dropped", {7'd0, req_n_o}, 8'd1);
        xfer_done = 1'b1;
        int_req = '0;
        step(1);
        xfer_done = 1'b0;
        step(1);
        chk("R9 released in client role", {6'd0, busy_oe_o, own_o}, 8'd0);
        int_req = 3'b010;
        step(1);
        chk("R6 parked: no request", {7'd0, req_n_o}, 8'd1);
        chk("R6 parked: owns directly", {7'd0, own_o}, 8'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule